// File: doc/BRIEF.md
# Status Beeper

This block turns two kinds of event into short square-wave beeps on a one-bit audio line, for a small amplifier and speaker. After its own reset it looks once at the host processor's reset level. If that level reads high, it plays a power-up beep at the higher pitch. After that it plays a status beep at the lower pitch each time the active-low status request line goes from high to low. A host that wants a series of beeps pulses the request line repeatedly.

Both pitches and the beep length come from a parameterised system clock frequency. Each half period of the tone is the clock frequency divided by twice the pitch, rounded to the nearest whole number of cycles. A request that arrives while a beep is playing is remembered and played once the current beep has finished. While the block is silent, the tone output stays low.

Top module: `status_beeper`

## Requirements
- R1: While local reset (`rstN` low) is applied, `tone` and `busy` are both 0.
- R2: If the synchronised `hostResetLvl` reads 1 shortly after local reset is released, a beep at pitch `PWRUP_HZ` starts within 20 cycles.
- R3: If `hostResetLvl` reads 0 at that moment, no power-up beep is played.
- R4: Every beep keeps `busy` at 1 for exactly `CLK_HZ*BEEP_MS/1000` consecutive cycles.
- R5: A high-to-low transition on `statusReqN` (passed through a two-flop synchroniser) starts a beep at pitch `STATUS_HZ` within 5 cycles when the block is idle.
- R6: `tone` is 0 whenever `busy` is 0, and `tone` is 1 in the first cycle of each beep.
- R7: A request arriving during a beep is held, and its beep starts after exactly one idle cycle once the current beep ends. Any further requests during the same beep merge into that single held request.
- R8: Only a falling edge requests a beep. Holding `statusReqN` low, or raising it, starts nothing.
- R9: Each tone half period is `round(CLK_HZ / (2*pitch))` cycles, with `tone` toggling at that spacing throughout the beep.
- R10: The power-up beep is decided once per local reset. Later changes on `hostResetLvl` start no beep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at `CLK_HZ` |
| rstN | input | 1 | Local reset, active low |
| hostResetLvl | input | 1 | Host reset level, asynchronous; sampled once after local reset |
| statusReqN | input | 1 | Status beep request, active low, asynchronous |
| tone | output | 1 | Square-wave audio output |
| busy | output | 1 | High while a beep is playing |

## Verification
A wrong burst counter shows up as a `busy` run that is too long or too short, and this is visible at the first falling edge of `busy`, 300 ms into a beep. A wrong divider or a wrong pitch select shows up as a `tone` spacing that differs from the expected half period, and this is visible within one half period of the beep's start. A corrupted held-request flag or a faulty edge detector shows up in the cycles right after a beep ends: a missing or extra beep appears, or the idle gap between beeps is not exactly one cycle.

// File: rtl/status_beeper_pkg.sv
package status_beeper_pkg;

  typedef enum logic [1:0] {
    ST_WARM,
    ST_IDLE,
    ST_PLAY
  } ctrlState_t;

  typedef struct packed {
    logic start;
    logic pitchHi;
  } beepCmd_t;

  function automatic int halfCycles(input int clkHz, input int toneHz);
    return (clkHz + toneHz) / (2 * toneHz);
  endfunction

endpackage

// File: rtl/beep_sync.sv
module beep_sync (
  input  logic clk,
  input  logic rstN,
  input  logic hostLvl,
  input  logic reqN,
  output logic hostSync,
  output logic reqFall
);
  logic hostMeta;
  logic reqMeta, reqSync, reqPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostMeta <= 1'b0;
      hostSync <= 1'b0;
      reqMeta  <= 1'b1;
      reqSync  <= 1'b1;
      reqPrev  <= 1'b1;
    end else begin
      hostMeta <= hostLvl;
      hostSync <= hostMeta;
      reqMeta  <= reqN;
      reqSync  <= reqMeta;
      reqPrev  <= reqSync;
    end
  end

  assign reqFall = reqPrev & ~reqSync;
endmodule

// File: rtl/beep_ctrl.sv
module beep_ctrl
  import status_beeper_pkg::*;
#(
  parameter int WARM_CYC = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     hostSync,
  input  logic     reqFall,
  input  logic     beepDone,
  output beepCmd_t cmd
);
  localparam int WARM_W = $clog2(WARM_CYC + 1);

  ctrlState_t state, stateNext;
  logic [WARM_W-1:0] warmCnt;
  logic pending, pendingNext;

  always_comb begin
    stateNext   = state;
    cmd         = '0;
    pendingNext = pending | reqFall;
    case (state)
      ST_WARM: begin
        if (warmCnt == WARM_W'(WARM_CYC)) begin
          if (hostSync) begin
            cmd.start   = 1'b1;
            cmd.pitchHi = 1'b1;
            stateNext   = ST_PLAY;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      ST_IDLE: begin
        if (pending || reqFall) begin
          cmd.start   = 1'b1;
          cmd.pitchHi = 1'b0;
          pendingNext = 1'b0;
          stateNext   = ST_PLAY;
        end
      end
      ST_PLAY: begin
        if (beepDone) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WARM;
      warmCnt <= '0;
      pending <= 1'b0;
    end else begin
      state   <= stateNext;
      pending <= pendingNext;
      if (state == ST_WARM) warmCnt <= warmCnt + 1'b1;
    end
  end
endmodule

// File: rtl/beep_dp.sv
module beep_dp
  import status_beeper_pkg::*;
#(
  parameter int BEEP_CYC = 300000,
  parameter int HALF_HI  = 550,
  parameter int HALF_LO  = 650
) (
  input  logic     clk,
  input  logic     rstN,
  input  beepCmd_t cmd,
  output logic     tone,
  output logic     busy,
  output logic     beepDone
);
  localparam int HALF_MAX = (HALF_HI > HALF_LO) ? HALF_HI : HALF_LO;
  localparam int LEN_W    = (BEEP_CYC > 1) ? $clog2(BEEP_CYC) : 1;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);

  logic [LEN_W-1:0]  lenCnt;
  logic [HALF_W-1:0] halfCnt;
  logic              selHi;
  logic              active;
  logic [HALF_W-1:0] halfReload;

  assign halfReload = selHi ? HALF_W'(HALF_HI - 1) : HALF_W'(HALF_LO - 1);
  assign beepDone   = active && (lenCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenCnt  <= '0;
      halfCnt <= '0;
      selHi   <= 1'b0;
      active  <= 1'b0;
      tone    <= 1'b0;
    end else if (cmd.start && !active) begin
      lenCnt  <= LEN_W'(BEEP_CYC - 1);
      halfCnt <= cmd.pitchHi ? HALF_W'(HALF_HI - 1) : HALF_W'(HALF_LO - 1);
      selHi   <= cmd.pitchHi;
      active  <= 1'b1;
      tone    <= 1'b1;
    end else if (beepDone) begin
      active <= 1'b0;
      tone   <= 1'b0;
    end else if (active) begin
      lenCnt <= lenCnt - 1'b1;
      if (halfCnt == '0) begin
        halfCnt <= halfReload;
        tone    <= ~tone;
      end else begin
        halfCnt <= halfCnt - 1'b1;
      end
    end
  end

  assign busy = active;
endmodule

// File: rtl/status_beeper.sv
module status_beeper
  import status_beeper_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int PWRUP_HZ  = 909,
  parameter int STATUS_HZ = 769,
  parameter int BEEP_MS   = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic hostResetLvl,
  input  logic statusReqN,
  output logic tone,
  output logic busy
);
  localparam int BEEP_CYC = CLK_HZ / 1000 * BEEP_MS;
  localparam int HALF_HI  = halfCycles(CLK_HZ, PWRUP_HZ);
  localparam int HALF_LO  = halfCycles(CLK_HZ, STATUS_HZ);

  logic     hostSync, reqFall, beepDone;
  beepCmd_t cmd;

  beep_sync uSync (
    .clk     (clk),
    .rstN    (rstN),
    .hostLvl (hostResetLvl),
    .reqN    (statusReqN),
    .hostSync(hostSync),
    .reqFall (reqFall)
  );

  beep_ctrl #(.WARM_CYC(2)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostSync(hostSync),
    .reqFall (reqFall),
    .beepDone(beepDone),
    .cmd     (cmd)
  );

  beep_dp #(
    .BEEP_CYC(BEEP_CYC),
    .HALF_HI (HALF_HI),
    .HALF_LO (HALF_LO)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .tone    (tone),
    .busy    (busy),
    .beepDone(beepDone)
  );
endmodule

// File: rtl/status_beeper_chk.sv
module status_beeper_chk #(
  parameter int BEEP_CYC = 300000,
  parameter int HALF_HI  = 550,
  parameter int HALF_LO  = 650
) (
  input logic clk,
  input logic rstN,
  input logic tone,
  input logic busy
);
  logic [31:0] runLen;
  logic [31:0] gap;
  logic        toneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
      gap    <= '0;
      toneQ  <= 1'b0;
    end else begin
      runLen <= busy ? runLen + 1 : '0;
      toneQ  <= tone;
      gap    <= (tone != toneQ) ? 32'd1 : gap + 1;
    end
  end

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tone);

  assert_start_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> tone);

  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == BEEP_CYC));

  assert_half_period_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(tone)) |-> (gap == HALF_HI || gap == HALF_LO));
endmodule

bind status_beeper status_beeper_chk #(
  .BEEP_CYC(BEEP_CYC),
  .HALF_HI (HALF_HI),
  .HALF_LO (HALF_LO)
) uChk (
  .clk (clk),
  .rstN(rstN),
  .tone(tone),
  .busy(busy)
);

// File: tb/sim_status_beeper.sv
`timescale 1ns/1ps
module sim_status_beeper;
  localparam int CLK = 20000;
  localparam int PU  = 909;
  localparam int ST  = 769;
  localparam int MS  = 300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostResetLvl = 1'b1;
  logic statusReqN = 1'b1;
  logic tone, busy;
  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  status_beeper #(.CLK_HZ(CLK), .PWRUP_HZ(PU), .STATUS_HZ(ST), .BEEP_MS(MS)) u0 (
    .clk(clk), .rstN(rstN), .hostResetLvl(hostResetLvl),
    .statusReqN(statusReqN), .tone(tone), .busy(busy)
  );

  function automatic int expHalf(input int f);
    real r;
    r = real'(CLK) / (2.0 * real'(f));
    return $rtoi(r + 0.5);
  endfunction

  function automatic int expLen();
    return (CLK * MS) / 1000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measureBeep(input int waitMax, output int waited, output bit seen,
                             output int len, output int hmin, output int hmax,
                             output bit firstHi, output bit endLow);
    int seg;
    bit prev;
    waited = 0; len = 0; hmin = 1 << 30; hmax = 0; firstHi = 0; endLow = 1;
    while (!busy && waited < waitMax) begin
      @(negedge clk);
      waited++;
    end
    seen = busy;
    if (!seen) return;
    firstHi = tone;
    prev = tone;
    seg = 0;
    while (busy) begin
      len++;
      if (tone == prev) seg++;
      else begin
        if (seg < hmin) hmin = seg;
        if (seg > hmax) hmax = seg;
        seg = 1;
        prev = tone;
      end
      @(negedge clk);
    end
    endLow = !tone;
  endtask

  task automatic checkBeep(input string req, input int waitMax, input int half, input int expWait);
    int waited, len, hmin, hmax;
    bit seen, firstHi, endLow;
    measureBeep(waitMax, waited, seen, len, hmin, hmax, firstHi, endLow);
    chk(seen, req, "beep started", int'(seen), 1);
    if (!seen) return;
    if (expWait >= 0) chk(waited == expWait, req, "idle gap before beep", waited, expWait);
    chk(len == expLen(), "R4", "busy length", len, expLen());
    chk(hmin == half && hmax == half, "R9", "half period", (hmin == half) ? hmax : hmin, half);
    chk(firstHi, "R6", "tone high at start", int'(firstHi), 1);
    chk(endLow, "R6", "tone low after beep", int'(!endLow), 0);
  endtask

  task automatic checkSilent(input string req, input int n);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || tone) hits++;
    end
    chk(hits == 0, req, "cycles with busy or tone", hits, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nFail++;
      $display("FAIL watchdog (all R) actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4211));
    // R1: reset state
    waitCyc(4);
    chk(!tone && !busy, "R1", "outputs in reset", {tone, busy}, 0);
    rstN = 1'b1;
    // R2: power-up beep at high pitch
    checkBeep("R2", 20, expHalf(PU), -1);
    // R5: random status pulses while idle
    for (int i = 0; i < 4; i++) begin
      int idle, w;
      idle = $urandom_range(5, 60);
      w = $urandom_range(1, 30);
      waitCyc(idle);
      statusReqN = 1'b0;
      fork
        begin waitCyc(w); statusReqN = 1'b1; end
      join_none
      checkBeep("R5", 5, expHalf(ST), -1);
    end
    // R8: held low then released: no extra beep
    waitCyc(10);
    statusReqN = 1'b0;
    checkBeep("R5", 5, expHalf(ST), -1);
    checkSilent("R8", 40);
    statusReqN = 1'b1;
    checkSilent("R8", 40);
    // R10: host reset toggling after start-up has no effect
    hostResetLvl = 1'b0;
    waitCyc(10);
    hostResetLvl = 1'b1;
    checkSilent("R10", 60);
    // R7: requests during a beep are held and merged
    statusReqN = 1'b0;
    fork
      begin
        waitCyc(4); statusReqN = 1'b1;
        waitCyc(100); statusReqN = 1'b0;
        waitCyc(4); statusReqN = 1'b1;
        waitCyc(50); statusReqN = 1'b0;
        waitCyc(4); statusReqN = 1'b1;
      end
    join_none
    checkBeep("R5", 5, expHalf(ST), -1);
    checkBeep("R7", 5, expHalf(ST), 1);
    checkSilent("R7", 100);
    // R3: second start-up with host reset low
    rstN = 1'b0;
    hostResetLvl = 1'b0;
    waitCyc(5);
    chk(!tone && !busy, "R1", "outputs in reset", {tone, busy}, 0);
    rstN = 1'b1;
    checkSilent("R3", 100);
    statusReqN = 1'b0;
    fork
      begin waitCyc(3); statusReqN = 1'b1; end
    join_none
    checkBeep("R5", 5, expHalf(ST), -1);
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule